// File: doc/BRIEF.md
# I2C Serial Memory Slave with Page Write

This block is the bus-side controller of a 256-byte memory that sits behind a two-wire I2C slave interface. It watches already-synchronised SCL and SDA, finds START and STOP conditions, decodes its own 7-bit device address, and returns data or acknowledge bits by pulling SDA low. The memory itself is a register array in the block. An internal address counter drives all reads and writes.

A master sets the address with a one-byte word address and then streams data. The data lands in a 16-byte page buffer and reaches the array only on STOP. After that, a timed write cycle keeps the memory silent on the bus. Reads can use the counter as it stands, or follow a word-address-only write and a repeated START. Reads carry on for as long as the master keeps acknowledging. A write-control input blocks every change to the array.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A device byte is accepted only when its bits [7:1] equal {1, dev_pins_i[5:0]}. Bit 0 selects the direction: 1 means read, 0 means write. A byte that does not match is never acknowledged, and the slave stays silent until the next START.
- R2: The slave pulls SDA low during the ninth clock after a matched device byte, after a word address, and after each accepted data byte. The pull-down only changes while SCL is low.
- R3: In a write that starts at word address W, data byte k (counting from 0) goes to address {W[7:4], (W[3:0]+k) mod 16}. A 17th or later byte overwrites earlier bytes of the same page. The upper four counter bits never change during a write.
- R4: The array changes only when a STOP ends a write that carried data. A repeated START drops data that has not yet been committed. A write that ends after the word address starts no write cycle.
- R5: After a commit, the memory device address is not acknowledged for WR_CYCLES clocks. After that, it is acknowledged again.
- R6: While wc_i is 1, the word address is still acknowledged and loads the counter. Data bytes are not acknowledged, the array stays unchanged, and no write cycle starts.
- R7: The counter holds one past the last location read or written. A read with no word address returns the byte at the counter.
- R8: A write of only a word address, followed by a repeated START and a read, returns the byte at that word address.
- R9: Each master acknowledge during a read sends the next byte, and the counter wraps from 255 to 0. A master not-acknowledge ends the read.
- R10: After reset, SDA is released, every array byte reads 0, and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data (wired line level) |
| dev_pins_i | input | 6 | Strap value for the low six device-address bits |
| wc_i | input | 1 | Write control; 1 blocks writes to the array |
| sda_pd_o | output | 1 | 1 pulls the SDA line low |

## Verification
The bench builds the block with WR_CYCLES = 300 and the default 4-bit page index. A probe sent right after STOP therefore lands inside the write cycle, and a second probe a little later lands after it, so both edges of the busy window are exercised in a short run. Random pages of 1 to 20 bytes cross the 16-byte wrap, and a directed read starting at 0xFE crosses the top of the address space.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_t;
  typedef enum logic [1:0] {PH_DEV, PH_WORD, PH_DATA} ph_t;

  // Device header match: fixed leading one, then the six strap bits.
  function automatic logic dev_match(input logic [6:0] hdr, input logic [5:0] pins);
    return hdr == {1'b1, pins};
  endfunction

  // Counter step inside a page: only the low pb bits advance.
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a,
                                                  input int unsigned pb);
    logic [ADDR_W-1:0] m;
    m = ADDR_W'((1 << pb) - 1);
    return (a & ~m) | ((a + ADDR_W'(1)) & m);
  endfunction

  // Array address of buffer slot idx within the page holding base.
  function automatic logic [ADDR_W-1:0] page_slot(input logic [ADDR_W-1:0] base,
                                                  input int unsigned idx,
                                                  input int unsigned pb);
    logic [ADDR_W-1:0] m;
    m = ADDR_W'((1 << pb) - 1);
    return (base & ~m) | (ADDR_W'(idx) & m);
  endfunction

endpackage

// File: rtl/i2cee_bus_cond.sv
module i2cee_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = ~scl_q & scl_i;
  assign fall_o  = scl_q & ~scl_i;

endmodule

// File: rtl/i2cee_wr_timer.sv
module i2cee_wr_timer #(
  parameter int WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load_i)       cnt <= CW'(WR_CYCLES);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign busy_o = (cnt != '0);

  AST_TIMER_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> busy_o); // R5

endmodule

// File: rtl/i2cee_page_buf.sv
module i2cee_page_buf #(
  parameter int PAGE_BITS = 4,
  parameter int DW        = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr_i,
  input  logic                             we_i,
  input  logic [PAGE_BITS-1:0]             idx_i,
  input  logic [DW-1:0]                    data_i,
  output logic [(1<<PAGE_BITS)-1:0][DW-1:0] data_o,
  output logic [(1<<PAGE_BITS)-1:0]        valid_o
);
  localparam int ENTRIES = 1 << PAGE_BITS;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_o[g] <= 1'b0;
        data_o[g]  <= '0;
      end else if (clr_i) begin
        valid_o[g] <= 1'b0;
      end else if (we_i && idx_i == PAGE_BITS'(g)) begin
        valid_o[g] <= 1'b1;
        data_o[g]  <= data_i;
      end
    end
  end

  AST_SLOT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    we_i && !clr_i |=> valid_o[$past(idx_i)]); // R3

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2cee_pkg::*;
#(
  parameter int WR_CYCLES = 5000,
  parameter int PAGE_BITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [5:0] dev_pins_i,
  input  logic       wc_i,
  output logic       sda_pd_o
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;

  st_t               st;
  ph_t               ph;
  logic [3:0]        bitcnt;
  logic [DATA_W-1:0] rx_sr, tx_sr;
  logic              rw_q, mack_q;
  logic [ADDR_W-1:0] cnt;
  logic [DATA_W-1:0] mem [DEPTH];

  logic start, stop, rise, fall, busy;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] pbuf;
  logic [PAGE_BYTES-1:0]             pvalid;

  // Named internal events
  logic              ev_byte_done, dev_ok, ev_dev_ack, ev_data_store;
  logic              ev_commit, ev_tx_load, buf_clr;
  logic [DATA_W-1:0] rd_data;

  i2cee_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
  );

  i2cee_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(ev_commit), .busy_o(busy)
  );

  i2cee_page_buf #(.PAGE_BITS(PAGE_BITS), .DW(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .we_i(ev_data_store),
    .idx_i(cnt[PAGE_BITS-1:0]), .data_i(rx_sr),
    .data_o(pbuf), .valid_o(pvalid)
  );

  assign ev_byte_done  = (st == ST_RX) && fall && (bitcnt == 4'd8);
  assign dev_ok        = dev_match(rx_sr[7:1], dev_pins_i) && !busy;
  assign ev_dev_ack    = ev_byte_done && (ph == PH_DEV) && dev_ok;
  assign ev_data_store = ev_byte_done && (ph == PH_DATA) && !wc_i;
  assign ev_commit     = stop && !wc_i && (|pvalid);
  assign buf_clr       = start | stop;
  assign ev_tx_load    = fall && (((st == ST_ACK) && (ph == PH_DEV) && rw_q) ||
                                  ((st == ST_MACK) && mack_q));
  assign rd_data       = mem[cnt];

  // Protocol sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_DEV;
      bitcnt   <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      cnt      <= '0;
      sda_pd_o <= 1'b0;
    end else if (start) begin
      st       <= ST_RX;
      ph       <= PH_DEV;
      bitcnt   <= '0;
      sda_pd_o <= 1'b0;
    end else if (stop) begin
      st       <= ST_IDLE;
      sda_pd_o <= 1'b0;
    end else begin
      if (ev_tx_load) begin
        st       <= ST_TX;
        tx_sr    <= rd_data;
        sda_pd_o <= ~rd_data[7];
        cnt      <= cnt + ADDR_W'(1);
        bitcnt   <= 4'd1;
      end else begin
        unique case (st)
          ST_RX: begin
            if (rise && bitcnt < 4'd8) begin
              rx_sr  <= {rx_sr[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end
            if (ev_byte_done) begin
              unique case (ph)
                PH_DEV: begin
                  if (dev_ok) begin
                    st       <= ST_ACK;
                    sda_pd_o <= 1'b1;
                    rw_q     <= rx_sr[0];
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                PH_WORD: begin
                  st       <= ST_ACK;
                  sda_pd_o <= 1'b1;
                  cnt      <= rx_sr;
                end
                default: begin
                  if (!wc_i) begin
                    st       <= ST_ACK;
                    sda_pd_o <= 1'b1;
                    cnt      <= page_next(cnt, PAGE_BITS);
                  end else begin
                    st <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (fall) begin
              sda_pd_o <= 1'b0;
              bitcnt   <= '0;
              st       <= ST_RX;
              ph       <= (ph == PH_DEV) ? PH_WORD : PH_DATA;
            end
          end
          ST_TX: begin
            if (fall) begin
              if (bitcnt == 4'd8) begin
                sda_pd_o <= 1'b0;
                st       <= ST_MACK;
              end else begin
                tx_sr    <= {tx_sr[6:0], 1'b0};
                sda_pd_o <= ~tx_sr[6];
                bitcnt   <= bitcnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (rise) mack_q <= ~sda_i;
            if (fall) st <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // Array with page commit on STOP
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ev_commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pvalid[i]) mem[page_slot(cnt, i, PAGE_BITS)] <= pbuf[i];
    end
  end

  AST_NO_ACK_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte_done && (ph == PH_DEV) && !dev_match(rx_sr[7:1], dev_pins_i) |=> !sda_pd_o); // R1
  AST_PD_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pd_o) |-> !scl_i); // R2
  AST_PAGE_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_store |=> cnt[ADDR_W-1:PAGE_BITS] == $past(cnt[ADDR_W-1:PAGE_BITS])); // R3
  AST_CYCLE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop)); // R4
  AST_SILENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pd_o); // R5
  AST_WC_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wc_i)); // R6

endmodule

// File: tb/sim_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_slave;
  localparam int WRC = 300;
  localparam int Q   = 3;
  localparam logic [5:0] PINS = 6'b101101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wc = 1'b0;
  logic sda_pd;
  wire  sda_line = m_sda & ~sda_pd;

  int checks = 0, errors = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] cnt_ref;
  logic [7:0] wbuf [32];

  always #4 clk = ~clk;

  i2c_eeprom_slave #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .dev_pins_i(PINS), .wc_i(wc), .sda_pd_o(sda_pd)
  );

  function automatic logic [7:0] slot(input logic [7:0] a, input int k);
    logic [3:0] lo;
    lo = 4'((int'(a[3:0]) + k) % 16);
    return {a[7:4], lo};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic i2c_start;
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; m_sda = 1'b0; wq; m_scl = 1'b0; wq;
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wq; m_scl = 1'b1; wq; m_sda = 1'b1; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq; m_scl = 1'b1; wq; wq; m_scl = 1'b0; wq;
    end
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; ack = !sda_line; wq; m_scl = 1'b0; wq;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq; m_scl = 1'b1; wq; b = {b[6:0], sda_line}; wq; m_scl = 1'b0;
    end
    wq; m_sda = !mack; wq; m_scl = 1'b1; wq; wq; m_scl = 1'b0; wq; m_sda = 1'b1;
  endtask

  function automatic logic [7:0] devb(input bit rd);
    return {1'b1, PINS, rd};
  endfunction

  // Write n bytes from wbuf at word address a; checks acks, updates model.
  task automatic do_write(input logic [7:0] a, input int n);
    bit ack;
    i2c_start;
    send_byte(devb(0), ack);   chk(ack, "R1 device ack on write", ack, 1);
    send_byte(a, ack);         chk(ack, "R2 word address ack", ack, 1);
    cnt_ref = a;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      if (wc) chk(!ack, "R6 data nack with write control", ack, 0);
      else    chk(ack, "R2 data ack", ack, 1);
    end
    i2c_stop;
    if (!wc) begin
      for (int i = 0; i < n; i++) ref_mem[slot(a, i)] = wbuf[i];
      cnt_ref = slot(a, n);
    end
  endtask

  task automatic probe(input bit exp_ack, input string tag);
    bit ack;
    i2c_start; send_byte(devb(0), ack); i2c_stop;
    chk(ack == exp_ack, tag, ack, exp_ack);
  endtask

  task automatic read_run(input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(b == ref_mem[cnt_ref], tag, b, ref_mem[cnt_ref]);
      cnt_ref = cnt_ref + 8'd1;
    end
  endtask

  task automatic cur_read(input int n, input string tag);
    bit ack;
    i2c_start;
    send_byte(devb(1), ack); chk(ack, "R1 device ack on read", ack, 1);
    read_run(n, tag);
    i2c_stop;
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string tag);
    bit ack;
    i2c_start;
    send_byte(devb(0), ack); chk(ack, "R8 device ack", ack, 1);
    send_byte(a, ack);       chk(ack, "R8 word ack", ack, 1);
    cnt_ref = a;
    i2c_start;
    send_byte(devb(1), ack); chk(ack, "R8 read ack after restart", ack, 1);
    read_run(n, tag);
    i2c_stop;
  endtask

  task automatic wait_cycle; repeat (WRC + 20) @(negedge clk); endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] a, b;
    int n;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    cnt_ref = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk(sda_pd == 1'b0, "R10 SDA released after reset", sda_pd, 0);
    cur_read(2, "R10 zero array and counter after reset");

    // R1: foreign addresses
    i2c_start; send_byte({1'b1, PINS ^ 6'b000100, 1'b0}, ack); i2c_stop;
    chk(!ack, "R1 strap mismatch ignored", ack, 0);
    i2c_start; send_byte({1'b0, PINS, 1'b1}, ack); i2c_stop;
    chk(!ack, "R1 leading zero ignored", ack, 0);

    // Byte write, busy window, random read
    wbuf[0] = 8'hA5;
    do_write(8'h10, 1);
    probe(1'b0, "R5 no ack during write cycle");
    wait_cycle;
    probe(1'b1, "R5 ack after write cycle");
    rand_read(8'h10, 1, "R8 random read of written byte");

    // Directed page wrap: 18 bytes from 0x2E
    for (int i = 0; i < 18; i++) wbuf[i] = 8'(8'h60 + i);
    do_write(8'h2E, 18);
    wait_cycle;
    cur_read(1, "R7 current read after page write");
    rand_read(8'h20, 16, "R3 page wrap and overwrite");

    // Random pages
    for (int it = 0; it < 6; it++) begin
      a = 8'($urandom % 256);
      n = 1 + int'($urandom % 20);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(a, n);
      wait_cycle;
      cur_read(1, "R7 counter after random page");
      rand_read({a[7:4], 4'h0}, 16, "R3 random page contents");
    end

    // Sequential wrap across 255 -> 0
    rand_read(8'hFE, 4, "R9 sequential read wrap");
    cur_read(1, "R7 counter after sequential read");

    // Write control high
    wc = 1'b1;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(8'h40, 3);
    probe(1'b1, "R6 no write cycle with write control");
    wc = 1'b0;
    cnt_ref = 8'h40;
    cur_read(3, "R6 array unchanged and counter loaded");

    // Data lost on repeated START, no write cycle
    i2c_start;
    send_byte(devb(0), ack); chk(ack, "R4 device ack", ack, 1);
    send_byte(8'h80, ack);   chk(ack, "R4 word ack", ack, 1);
    send_byte(ref_mem[8'h80] ^ 8'hFF, ack); chk(ack, "R4 data ack", ack, 1);
    cnt_ref = 8'h81;
    i2c_start;
    send_byte(devb(1), ack); chk(ack, "R4 read after restart", ack, 1);
    recv_byte(1'b0, b);
    chk(b == ref_mem[cnt_ref], "R7 counter advanced by dropped byte", b, ref_mem[cnt_ref]);
    i2c_stop;
    probe(1'b1, "R4 no write cycle after restart");
    rand_read(8'h80, 1, "R4 array unchanged without STOP");

    // Word address only, then STOP: no cycle
    i2c_start; send_byte(devb(0), ack); send_byte(8'h05, ack); i2c_stop;
    probe(1'b1, "R4 no write cycle without data");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule